// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

This block is a purely combinational binary adder. It adds two operands and a single carry-in bit, and it returns the sum together with a carry-out. There are no registers, so the outputs follow the inputs within the same time step.

The operand width is split into equal groups. Each bit forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). Each group reduces its bits to a group generate and a group propagate. A second look-ahead level turns those group summaries and the carry-in into the carry entering every group and the final carry-out.

Inside a group, each internal carry is a flattened sum of products. No carry is built from another carry. Each sum bit is the XOR of the bit's propagate term and the carry entering that bit.

The defaults give a 16-bit adder with four 4-bit groups. The carries into bits 4, 8 and 12 and the carry-out all come from the upper look-ahead level.

Top module: `la_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit WIDTH (bit 16 by default) of the full-precision sum `op_a + op_b + carry_in`.
- R3: With both operands zero, `sum_out` equals `carry_in` (0x0000 or 0x0001) and `carry_out` is 0.
- R4: With both operands 0xFFFF, `sum_out` is 0xFFFE when `carry_in`=0 and 0xFFFF when `carry_in`=1, and `carry_out` is 1 in both cases.
- R5: 0xFFFF plus 0x0001 with `carry_in`=0, and 0xFFFF plus 0x0000 with `carry_in`=1, both give `sum_out`=0x0000 and `carry_out`=1.
- R6: When every bit propagates (`op_a ^ op_b` = 0xFFFF), `carry_in`=0 gives `sum_out`=0xFFFF with `carry_out`=0, and `carry_in`=1 gives `sum_out`=0x0000 with `carry_out`=1.
- R7: A carry leaving the top bit of one group enters the next group, whether that group is one or several positions above. For example, 0x000F+0x0001=0x0010, 0x0FFF+0x0001=0x1000 and 0xF000+0x1000 gives 0x0000 with `carry_out`=1.
- R8: The outputs depend only on the present inputs. A new input value is reflected at the outputs without any clock edge.
- R9: When no bit position has both operand bits set and `carry_in`=0, `sum_out` equals `op_a | op_b` and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (16) | First addend |
| op_b | input | WIDTH (16) | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH (16) | Low WIDTH bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that travels the whole upper level. This happens when every group propagates and only the carry-in, or a generate in the lowest group, sets the result. Random operands almost never make all sixteen propagate terms true at once. The stimulus therefore uses complementary operand pairs and all-ones operands with both carry-in values, together with single-group generates placed just below each group boundary. Random vectors then cover the general case against a full-precision reference sum.

// File: rtl/la_pkg.sv
`timescale 1ns/1ps
package la_pkg;

   // Widest span one look-ahead unit may cover.
   localparam int MAX_SPAN = 8;

   typedef logic [MAX_SPAN-1:0] span_t;

   // Carry out of position 'top' as a flattened sum of products:
   // every generate term ANDed with the propagates above it, plus the
   // carry-in ANDed with all propagates. No carry feeds another carry.
   function automatic logic sop_carry(input span_t g, input span_t p,
                                      input logic c0, input int top);
      logic acc;
      logic term;
      acc = c0;
      for (int k = 0; k < MAX_SPAN; k++)
         if (k <= top) acc = acc & p[k];
      for (int j = 0; j < MAX_SPAN; j++) begin
         if (j <= top) begin
            term = g[j];
            for (int k = 0; k < MAX_SPAN; k++)
               if (k > j && k <= top) term = term & p[k];
            acc = acc | term;
         end
      end
      return acc;
   endfunction

endpackage

// File: rtl/la_bit_gp.sv
`timescale 1ns/1ps
module la_bit_gp #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("la_bit_gp: WIDTH must be positive");
      end
   endgenerate

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign gen_o[i]  = a_i[i] & b_i[i];
      assign prop_o[i] = a_i[i] ^ b_i[i];
   end

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         // R9
         gp_excl_chk: assert ((gen_o & prop_o) == '0)
            else $error("generate and propagate both set");
      end
   end

endmodule

// File: rtl/la_cla_unit.sv
`timescale 1ns/1ps
module la_cla_unit #(
   parameter int N = 4
) (
   input  logic [N-1:0] gen_i,
   input  logic [N-1:0] prop_i,
   input  logic         cin_i,
   output logic [N-1:0] cin_vec_o,
   output logic         cout_o,
   output logic         grp_gen_o,
   output logic         grp_prop_o
);

   generate
      if (N < 1 || N > la_pkg::MAX_SPAN) begin : g_bad_span
         $error("la_cla_unit: N out of range");
      end
   endgenerate

   la_pkg::span_t g_ext;
   la_pkg::span_t p_ext;
   assign g_ext = la_pkg::span_t'(gen_i);
   assign p_ext = la_pkg::span_t'(prop_i);

   // Carry path: depends on cin_i.
   always_comb begin
      cin_vec_o[0] = cin_i;
      for (int i = 1; i < N; i++)
         cin_vec_o[i] = la_pkg::sop_carry(g_ext, p_ext, cin_i, i - 1);
      cout_o = la_pkg::sop_carry(g_ext, p_ext, cin_i, N - 1);
   end

   // Summary path: independent of cin_i, kept in its own process.
   always_comb begin
      grp_gen_o  = la_pkg::sop_carry(g_ext, p_ext, 1'b0, N - 1);
      grp_prop_o = &prop_i;
   end

   always_comb begin
      if (!$isunknown({gen_i, prop_i, cin_i})) begin
         for (int i = 1; i < N; i++) begin
            // R7
            carry_recur_chk: assert (cin_vec_o[i] ==
                                     (gen_i[i-1] | (prop_i[i-1] & cin_vec_o[i-1])))
               else $error("flattened carry %0d disagrees with recurrence", i);
         end
         // R2
         cout_recur_chk: assert (cout_o ==
                                 (gen_i[N-1] | (prop_i[N-1] & cin_vec_o[N-1])))
            else $error("unit carry-out disagrees with recurrence");
         // R6
         grp_excl_chk: assert (!(grp_prop_o && grp_gen_o))
            else $error("group generate and propagate both set");
      end
   end

endmodule

// File: rtl/la_slice.sv
`timescale 1ns/1ps
module la_slice #(
   parameter int GROUP = 4
) (
   input  logic [GROUP-1:0] gen_i,
   input  logic [GROUP-1:0] prop_i,
   input  logic             cin_i,
   output logic [GROUP-1:0] sum_o,
   output logic             cout_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);

   logic [GROUP-1:0] bit_cin;

   la_cla_unit #(.N(GROUP)) u_local (
      .gen_i      (gen_i),
      .prop_i     (prop_i),
      .cin_i      (cin_i),
      .cin_vec_o  (bit_cin),
      .cout_o     (cout_o),
      .grp_gen_o  (grp_gen_o),
      .grp_prop_o (grp_prop_o)
   );

   for (genvar i = 0; i < GROUP; i++) begin : g_sum
      assign sum_o[i] = prop_i[i] ^ bit_cin[i];
   end

endmodule

// File: rtl/la_adder.sv
`timescale 1ns/1ps
module la_adder #(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out
);

   localparam int NGRP = WIDTH / GROUP;

   generate
      if (GROUP < 1 || WIDTH % GROUP != 0) begin : g_bad_group
         $error("la_adder: WIDTH must be a multiple of GROUP");
      end
      if (NGRP > la_pkg::MAX_SPAN || GROUP > la_pkg::MAX_SPAN) begin : g_bad_span
         $error("la_adder: too many groups or group too wide");
      end
   endgenerate

   logic [WIDTH-1:0] bit_g;
   logic [WIDTH-1:0] bit_p;
   logic [NGRP-1:0]  slice_g;
   logic [NGRP-1:0]  slice_p;
   logic [NGRP-1:0]  slice_cout;
   logic [NGRP-1:0]  slice_cin;
   logic             top_g;
   logic             top_p;

   la_bit_gp #(.WIDTH(WIDTH)) u_gp (
      .a_i    (op_a),
      .b_i    (op_b),
      .gen_o  (bit_g),
      .prop_o (bit_p)
   );

   for (genvar s = 0; s < NGRP; s++) begin : g_slice
      la_slice #(.GROUP(GROUP)) u_slice (
         .gen_i      (bit_g[s*GROUP +: GROUP]),
         .prop_i     (bit_p[s*GROUP +: GROUP]),
         .cin_i      (slice_cin[s]),
         .sum_o      (sum_out[s*GROUP +: GROUP]),
         .cout_o     (slice_cout[s]),
         .grp_gen_o  (slice_g[s]),
         .grp_prop_o (slice_p[s])
      );
   end

   la_cla_unit #(.N(NGRP)) u_upper (
      .gen_i      (slice_g),
      .prop_i     (slice_p),
      .cin_i      (carry_in),
      .cin_vec_o  (slice_cin),
      .cout_o     (carry_out),
      .grp_gen_o  (top_g),
      .grp_prop_o (top_p)
   );

   always_comb begin
      if (!$isunknown({op_a, op_b, carry_in})) begin
         // R1
         sum_ref_chk: assert (sum_out == WIDTH'(op_a + op_b + WIDTH'(carry_in)))
            else $error("sum differs from full-precision reference");
         // R2
         cout_ref_chk: assert (carry_out ==
                               (({1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in)) >> WIDTH))
            else $error("carry-out differs from reference bit");
         // R2
         top_gp_chk: assert (carry_out == (top_g | (top_p & carry_in)))
            else $error("carry-out disagrees with upper summary");
         for (int s = 0; s < NGRP - 1; s++) begin
            // R7
            level_agree_chk: assert (slice_cout[s] == slice_cin[s+1])
               else $error("slice %0d carry-out differs from upper carry", s);
         end
         // R7
         last_agree_chk: assert (slice_cout[NGRP-1] == carry_out)
            else $error("last slice carry-out differs from adder carry-out");
      end
   end

endmodule

// File: tb/test_la_adder.sv
`timescale 1ns/1ps
module test_la_adder;

   logic        clk = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic [15:0] sum_out;
   logic        carry_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   la_adder i_la_adder (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum_out   (sum_out),
      .carry_out (carry_out)
   );

   task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c);
      @(posedge clk);
      op_a = a;
      op_b = b;
      carry_in = c;
      @(negedge clk);
   endtask

   task automatic compare(input string tag, input logic [16:0] exp);
      n_vec++;
      if ({carry_out, sum_out} !== exp) begin
         n_bad++;
         $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
                  tag, op_a, op_b, carry_in, carry_out, sum_out, exp[16], exp[15:0]);
      end
   endtask

   task automatic apply(input string tag, input logic [15:0] a, input logic [15:0] b,
                        input logic c, input logic [16:0] exp);
      drive(a, b, c);
      compare(tag, exp);
   endtask

   // R3: zero operands
   task automatic t_zeros();
      apply("R3", 16'h0000, 16'h0000, 1'b0, 17'h00000);
      apply("R3", 16'h0000, 16'h0000, 1'b1, 17'h00001);
   endtask

   // R4: all-ones operands
   task automatic t_all_ones();
      apply("R4", 16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE);
      apply("R4", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
   endtask

   // R5: wrap to zero
   task automatic t_wrap();
      apply("R5", 16'hFFFF, 16'h0001, 1'b0, 17'h10000);
      apply("R5", 16'hFFFF, 16'h0000, 1'b1, 17'h10000);
      apply("R5", 16'h0001, 16'hFFFF, 1'b0, 17'h10000);
   endtask

   // R6: every bit propagates
   task automatic t_prop_chain();
      logic [15:0] pats [4] = '{16'hFFFF, 16'hAAAA, 16'h1234, 16'h00FF};
      foreach (pats[i]) begin
         apply("R6", pats[i], ~pats[i], 1'b0, 17'h0FFFF);
         apply("R6", pats[i], ~pats[i], 1'b1, 17'h10000);
      end
   endtask

   // R7: carries crossing group boundaries
   task automatic t_group_edge();
      apply("R7", 16'h000F, 16'h0001, 1'b0, 17'h00010);
      apply("R7", 16'h00F0, 16'h0010, 1'b0, 17'h00100);
      apply("R7", 16'h0F00, 16'h0100, 1'b0, 17'h01000);
      apply("R7", 16'hF000, 16'h1000, 1'b0, 17'h10000);
      apply("R7", 16'h0FFF, 16'h0001, 1'b0, 17'h01000);
      apply("R7", 16'h0FFF, 16'h0000, 1'b1, 17'h01000);
      apply("R7", 16'h00FF, 16'h0F00, 1'b1, 17'h01000);
      apply("R7", 16'h8000, 16'h8000, 1'b1, 17'h10001);
   endtask

   // R9: no generating position
   task automatic t_no_generate();
      for (int i = 0; i < 200; i++) begin
         logic [15:0] a;
         logic [15:0] b;
         a = 16'($urandom);
         b = 16'($urandom) & ~a;
         apply("R9", a, b, 1'b0, {1'b0, a | b});
      end
   endtask

   // R8: outputs follow inputs without a clock edge
   task automatic t_comb();
      @(negedge clk);
      op_a = 16'h1234; op_b = 16'h0001; carry_in = 1'b0;
      #0.5;
      compare("R8", 17'h01235);
      op_a = 16'hFFFF; op_b = 16'h0000; carry_in = 1'b1;
      #0.5;
      compare("R8", 17'h10000);
   endtask

   // R1, R2: random operands against the full-precision sum
   task automatic t_random();
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         logic [15:0] b;
         logic        c;
         a = 16'($urandom);
         b = 16'($urandom);
         c = 1'($urandom);
         drive(a, b, c);
         compare("R1/R2", {1'b0, a} + {1'b0, b} + {16'b0, c});
      end
   endtask

   initial begin
      void'($urandom(32'h5A17));
      t_zeros();
      t_all_ones();
      t_wrap();
      t_prop_chain();
      t_group_edge();
      t_no_generate();
      t_comb();
      t_random();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule